// File: doc/BRIEF.md
# Indirect Pointer Fetch Sequencer

This block resolves the pointer stage of an indirect operand address for an 8-bit-compatible processor core with a 24-bit address space. On a start strobe it captures the addressing mode, the 8-bit operand, the index registers, the direct-page base, the data bank and the stack pointer. It then works out where the pointer lives in bank 0 and reads the pointer byte by byte over a request/ready memory port. Finally it applies any post-index and presents the resulting 24-bit address together with a one-cycle completion pulse.

Six indirect modes are handled, and each has its own mode code. They differ in four ways: where the index is added, how many pointer bytes are read, where the bank of the result comes from, and whether the post-index may carry into the bank. The core uses the result to issue its own data access. That data access is not part of this block.

Top module: `ptr_fetch_seq`

## Requirements
- R1: While reset is high, and after reset until the first accepted start, `mem_req` and `done` are 0 and `addr_out` is 0.
- R2: Mode codes are 0 = plain pointer, 1 = pointer then +Y, 2 = +X then pointer, 3 = long pointer, 4 = long pointer then +Y, 5 = stack pointer offset then +Y. The first pointer byte is read at bank 0, offset `dp_base + operand` (16-bit wrap). In mode 5 that offset is `stack_ptr + operand`. The address bits 23:16 of every pointer read are 0.
- R3: A read keeps `mem_req` and `mem_addr` steady until `mem_ready` is seen high. The next byte's request follows in the very next cycle. The bytes are taken low first, then high, then bank (modes 3 and 4 only), at consecutive 16-bit offsets that wrap from FFFF to 0000.
- R4: Mode 2 adds X to the operand before adding `dp_base`. In emulation the sum of operand and X is cut to 8 bits first. The result is `{data_bank, pointer}`, with no post-index.
- R5: Mode 0 yields `{data_bank, pointer}`.
- R6: In native mode (`emu`=0), modes 1 and 5 yield `{data_bank, pointer} + Y` over 24 bits, so a carry enters the bank.
- R7: In emulation, modes 1 and 5 yield `{data_bank, (pointer + Y) mod 2^16}`.
- R8: Mode 3 yields the 24-bit fetched pointer. Mode 4 yields that pointer + Y over 24 bits in both native and emulation mode.
- R9: An index register counts as its low 8 bits when `idx_wide` is 0 or `emu` is 1, and as all 16 bits otherwise.
- R10: `done` is high for exactly one cycle. That cycle is the second cycle after the cycle in which the last pointer byte was accepted. `addr_out` changes only at the edge that raises `done`, and it holds its value afterwards.
- R11: A start seen while a fetch is in progress, or a start carrying mode code 6 or 7, has no effect. No read is issued for it, and it does not change the result of the fetch in progress.
- R12: The first read request appears in the second cycle after the start strobe is sampled. Inputs other than `start` are captured at that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pointer fetch |
| mode | input | 3 | Indirect mode code (see R2) |
| operand | input | 8 | Instruction operand byte |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| idx_wide | input | 1 | Index registers are 16 bits wide |
| emu | input | 1 | Emulation mode flag |
| dp_base | input | 16 | Direct-page base |
| data_bank | input | 8 | Data bank |
| stack_ptr | input | 16 | Stack pointer |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte address |
| mem_rdata | input | 8 | Returned byte |
| mem_ready | input | 1 | Read completes this cycle |
| done | output | 1 | Final address valid pulse |
| addr_out | output | 24 | Final operand address |

## Verification
The cases hardest to reach from the ports are those where the pointer memory must hold particular values. The bank-carry difference between native and emulation mode needs a pointer near FFFF plus a Y large enough to overflow it. Wrapping of the pointer location needs a base and operand that land exactly on offset FFFF. The bench therefore plants chosen bytes in its memory model at computed locations, then runs the same fetch in both modes. A second start is injected in the middle of a stalled fetch, with altered inputs, to show that it changes nothing. Random ready stalls are laid over a long run of random modes, and every cycle is compared against a queue-based reference.

// File: rtl/ptr_fetch_pkg.sv
package ptr_fetch_pkg;

  typedef enum logic [2:0] {
    IM_PTR      = 3'd0,
    IM_PTR_Y    = 3'd1,
    IM_X_PTR    = 3'd2,
    IM_LPTR     = 3'd3,
    IM_LPTR_Y   = 3'd4,
    IM_STK_PTR_Y = 3'd5
  } ind_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_READ_LO,
    ST_READ_HI,
    ST_READ_BANK,
    ST_INDEX,
    ST_DONE
  } seq_state_e;

  function automatic logic mode_known(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic mode_long(input ind_mode_e m);
    return (m == IM_LPTR) || (m == IM_LPTR_Y);
  endfunction

endpackage

// File: rtl/idx_narrow.sv
module idx_narrow #(
  parameter int DATA_W = 8
) (
  input  logic [2*DATA_W-1:0] raw,
  input  logic                short_mode,
  output logic [2*DATA_W-1:0] eff
);
  localparam int OFS_W = 2 * DATA_W;

  always_comb begin
    if (short_mode) eff = OFS_W'(raw[DATA_W-1:0]);
    else            eff = raw;
  end
endmodule

// File: rtl/ptr_loc_calc.sv
module ptr_loc_calc
  import ptr_fetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ind_mode_e           mode,
  input  logic                emu,
  input  logic [DATA_W-1:0]   op,
  input  logic [2*DATA_W-1:0] xi,
  input  logic [2*DATA_W-1:0] dp,
  input  logic [2*DATA_W-1:0] sp,
  output logic [2*DATA_W-1:0] loc
);
  localparam int OFS_W = 2 * DATA_W;

  logic [DATA_W-1:0] op_x_short;
  logic [OFS_W-1:0]  op_wide;

  assign op_x_short = op + xi[DATA_W-1:0];
  assign op_wide    = OFS_W'(op);

  always_comb begin
    case (mode)
      IM_STK_PTR_Y: loc = sp + op_wide;
      IM_X_PTR: begin
        if (emu) loc = dp + OFS_W'(op_x_short);
        else     loc = dp + op_wide + xi;
      end
      default:     loc = dp + op_wide;
    endcase
  end
endmodule

// File: rtl/ptr_index_calc.sv
module ptr_index_calc
  import ptr_fetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ind_mode_e           mode,
  input  logic                emu,
  input  logic [DATA_W-1:0]   bank_reg,
  input  logic [DATA_W-1:0]   lo,
  input  logic [DATA_W-1:0]   hi,
  input  logic [DATA_W-1:0]   bk,
  input  logic [2*DATA_W-1:0] yi,
  output logic [3*DATA_W-1:0] final_addr
);
  localparam int OFS_W  = 2 * DATA_W;
  localparam int ADDR_W = 3 * DATA_W;

  logic [OFS_W-1:0]  ptr;
  logic [OFS_W-1:0]  short_sum;
  logic [ADDR_W-1:0] with_b;
  logic [ADDR_W-1:0] with_bk;

  assign ptr       = {hi, lo};
  assign short_sum = ptr + yi;
  assign with_b    = {bank_reg, ptr} + ADDR_W'(yi);
  assign with_bk   = {bk, ptr} + ADDR_W'(yi);

  always_comb begin
    case (mode)
      IM_PTR_Y, IM_STK_PTR_Y: final_addr = emu ? {bank_reg, short_sum} : with_b;
      IM_LPTR:                final_addr = {bk, ptr};
      IM_LPTR_Y:              final_addr = with_bk;
      default:                final_addr = {bank_reg, ptr};
    endcase
  end
endmodule

// File: rtl/ptr_fetch_seq.sv
module ptr_fetch_seq
  import ptr_fetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          mode,
  input  logic [DATA_W-1:0]   operand,
  input  logic [2*DATA_W-1:0] x_reg,
  input  logic [2*DATA_W-1:0] y_reg,
  input  logic                idx_wide,
  input  logic                emu,
  input  logic [2*DATA_W-1:0] dp_base,
  input  logic [DATA_W-1:0]   data_bank,
  input  logic [2*DATA_W-1:0] stack_ptr,
  output logic                mem_req,
  output logic [3*DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic                done,
  output logic [3*DATA_W-1:0] addr_out
);
  localparam int OFS_W  = 2 * DATA_W;
  localparam int ADDR_W = 3 * DATA_W;
  localparam int N_IDX  = 2;

  seq_state_e        state;
  ind_mode_e         mode_q;
  logic [DATA_W-1:0] op_q;
  logic [OFS_W-1:0]  xi_q, yi_q;
  logic              emu_q;
  logic [OFS_W-1:0]  dp_q, sp_q;
  logic [DATA_W-1:0] bank_q;
  logic [OFS_W-1:0]  loc_q;
  logic [DATA_W-1:0] lo_q, hi_q, bk_q;
  logic [ADDR_W-1:0] addr_q;

  logic [OFS_W-1:0]  idx_raw [N_IDX];
  logic [OFS_W-1:0]  idx_eff [N_IDX];
  logic              short_idx;
  logic [OFS_W-1:0]  loc_w;
  logic [ADDR_W-1:0] final_w;
  logic [OFS_W-1:0]  byte_ofs;

  assign short_idx  = emu | ~idx_wide;
  assign idx_raw[0] = x_reg;
  assign idx_raw[1] = y_reg;

  for (genvar g = 0; g < N_IDX; g++) begin : g_idx
    idx_narrow #(.DATA_W(DATA_W)) u_narrow (
      .raw        (idx_raw[g]),
      .short_mode (short_idx),
      .eff        (idx_eff[g])
    );
  end

  ptr_loc_calc #(.DATA_W(DATA_W)) u_loc (
    .mode (mode_q),
    .emu  (emu_q),
    .op   (op_q),
    .xi   (xi_q),
    .dp   (dp_q),
    .sp   (sp_q),
    .loc  (loc_w)
  );

  ptr_index_calc #(.DATA_W(DATA_W)) u_idx (
    .mode       (mode_q),
    .emu        (emu_q),
    .bank_reg   (bank_q),
    .lo         (lo_q),
    .hi         (hi_q),
    .bk         (bk_q),
    .yi         (yi_q),
    .final_addr (final_w)
  );

  always_comb begin
    case (state)
      ST_READ_HI:   byte_ofs = OFS_W'(1);
      ST_READ_BANK: byte_ofs = OFS_W'(2);
      default:      byte_ofs = '0;
    endcase
  end

  assign mem_req  = (state == ST_READ_LO) || (state == ST_READ_HI) ||
                    (state == ST_READ_BANK);
  assign mem_addr = {{DATA_W{1'b0}}, loc_q + byte_ofs};
  assign done     = (state == ST_DONE);
  assign addr_out = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= IM_PTR;
      op_q   <= '0;
      xi_q   <= '0;
      yi_q   <= '0;
      emu_q  <= 1'b0;
      dp_q   <= '0;
      sp_q   <= '0;
      bank_q <= '0;
      loc_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      bk_q   <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && mode_known(mode)) begin
            mode_q <= ind_mode_e'(mode);
            op_q   <= operand;
            xi_q   <= idx_eff[0];
            yi_q   <= idx_eff[1];
            emu_q  <= emu;
            dp_q   <= dp_base;
            sp_q   <= stack_ptr;
            bank_q <= data_bank;
            state  <= ST_CALC;
          end
        end
        ST_CALC: begin
          loc_q <= loc_w;
          state <= ST_READ_LO;
        end
        ST_READ_LO: begin
          if (mem_ready) begin
            lo_q  <= mem_rdata;
            state <= ST_READ_HI;
          end
        end
        ST_READ_HI: begin
          if (mem_ready) begin
            hi_q  <= mem_rdata;
            state <= mode_long(mode_q) ? ST_READ_BANK : ST_INDEX;
          end
        end
        ST_READ_BANK: begin
          if (mem_ready) begin
            bk_q  <= mem_rdata;
            state <= ST_INDEX;
          end
        end
        ST_INDEX: begin
          addr_q <= final_w;
          state  <= ST_DONE;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptr_fetch_seq_chk.sv
module ptr_fetch_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int BANK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [ADDR_W-1:0] addr_out
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_bank_zero_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ADDR_W-1 -: BANK_W] == '0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_gap_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(mem_req));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_out) |-> done);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

endmodule

bind ptr_fetch_seq ptr_fetch_seq_chk #(.ADDR_W(3*DATA_W), .BANK_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .done      (done),
  .addr_out  (addr_out)
);

// File: tb/ptr_fetch_seq_bench.sv
module ptr_fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  mode;
  logic [7:0]  operand;
  logic [15:0] x_reg, y_reg, dp_base, stack_ptr;
  logic        idx_wide, emu;
  logic [7:0]  data_bank;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_ready;
  logic        done;
  logic [23:0] addr_out;

  always #2 clk = ~clk;

  ptr_fetch_seq u_ptr_fetch_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
    .x_reg(x_reg), .y_reg(y_reg), .idx_wide(idx_wide), .emu(emu),
    .dp_base(dp_base), .data_bank(data_bank), .stack_ptr(stack_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .addr_out(addr_out)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit chk_on = 0;
  bit finished = 0;
  int stall_pct = 0;
  string cur_tag = "R5";

  logic [7:0] ovr [int unsigned];

  function automatic logic [7:0] mem_byte(input int unsigned a);
    if (ovr.exists(a)) return ovr[a];
    return 8'((a * 7) + ((a >> 8) * 13) + 'h3c);
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned act,
                     input int unsigned exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory side: ready pattern and returned byte, driven away from the edge
  always @(negedge clk) begin
    #1;
    mem_ready <= (stall_pct == 0) ? 1'b1 : (($urandom % 100) >= stall_pct);
    mem_rdata <= mem_byte(int'(mem_addr[15:0]));
  end

  // behavioural reference: queue of expected read offsets and the final result
  int          m_st = 0;
  int unsigned q_addr[$];
  int unsigned m_final = 0;
  int unsigned m_out = 0;
  string       m_tag = "R1";
  string       m_loc_tag = "R2";

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0;
      q_addr.delete();
      m_out = 0;
    end else begin
      case (m_st)
        0: if (start && mode < 3'd6) begin
          int unsigned xi, yi, loc, lo, hi, bk, ptr, b, md;
          md = mode;
          xi = (emu || !idx_wide) ? (x_reg & 'hFF) : x_reg;
          yi = (emu || !idx_wide) ? (y_reg & 'hFF) : y_reg;
          if (md == 5)      loc = (stack_ptr + operand) & 'hFFFF;
          else if (md == 2) loc = emu ? ((dp_base + ((operand + xi) & 'hFF)) & 'hFFFF)
                                      : ((dp_base + operand + xi) & 'hFFFF);
          else              loc = (dp_base + operand) & 'hFFFF;
          lo = mem_byte(loc);
          hi = mem_byte((loc + 1) & 'hFFFF);
          bk = mem_byte((loc + 2) & 'hFFFF);
          ptr = hi * 256 + lo;
          b = data_bank;
          q_addr.push_back(loc);
          q_addr.push_back((loc + 1) & 'hFFFF);
          if (md == 3 || md == 4) q_addr.push_back((loc + 2) & 'hFFFF);
          case (md)
            1, 5: m_final = emu ? (b * 65536 + ((ptr + yi) & 'hFFFF))
                                : ((b * 65536 + ptr + yi) & 'hFFFFFF);
            3:    m_final = bk * 65536 + ptr;
            4:    m_final = (bk * 65536 + ptr + yi) & 'hFFFFFF;
            default: m_final = b * 65536 + ptr;
          endcase
          m_tag = cur_tag;
          m_loc_tag = (md == 2) ? "R4" : "R2";
          m_st = 1;
        end
        1: m_st = 2;
        2: if (mem_ready) begin
          void'(q_addr.pop_front());
          if (q_addr.size() == 0) m_st = 3;
        end
        3: begin m_out = m_final; m_st = 4; end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && chk_on && !finished) begin
      chk(mem_req === (m_st == 2), (m_st == 1) ? "R12" : (m_st == 0 ? "R11" : "R3"),
          mem_req, (m_st == 2), "mem_req");
      if (m_st == 2 && mem_req === 1'b1)
        chk(mem_addr === {8'h00, q_addr[0][15:0]}, m_loc_tag, mem_addr,
            q_addr[0], "pointer read address");
      chk(done === (m_st == 4), "R10", done, (m_st == 4), "done");
      chk(addr_out === m_out[23:0], (m_st == 4) ? m_tag : "R10", addr_out, m_out,
          "addr_out");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic set_in(input logic [2:0] md, input logic [7:0] op,
                        input logic [15:0] x, input logic [15:0] y, input bit xw,
                        input bit em, input logic [15:0] d, input logic [7:0] b,
                        input logic [15:0] s);
    mode = md; operand = op; x_reg = x; y_reg = y; idx_wide = xw;
    emu = em; dp_base = d; data_bank = b; stack_ptr = s;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_st != 0) @(negedge clk);
    #1;
  endtask

  task automatic xact(input logic [2:0] md, input logic [7:0] op,
                      input logic [15:0] x, input logic [15:0] y, input bit xw,
                      input bit em, input logic [15:0] d, input logic [7:0] b,
                      input logic [15:0] s, input string tag);
    @(negedge clk); #1;
    set_in(md, op, x, y, xw, em, d, b, s);
    cur_tag = tag;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; mem_ready = 1'b1; mem_rdata = '0;
    set_in(3'd0, 8'h00, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0, 8'h00, 16'h0);
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0, "R1", mem_req, 0, "mem_req in reset");
    chk(done === 1'b0, "R1", done, 0, "done in reset");
    chk(addr_out === 24'h0, "R1", addr_out, 0, "addr_out in reset");
    #1; rst = 1'b0;
    chk_on = 1;
    repeat (2) @(negedge clk);
    chk(addr_out === 24'h0 && mem_req === 1'b0, "R1", addr_out, 0, "after reset");

    // R6 native carry into the bank, R7 emulation wrap
    ovr[32'h1234] = 8'hF0; ovr[32'h1235] = 8'hFF;
    xact(3'd1, 8'h34, 16'h0, 16'h0020, 1'b1, 1'b0, 16'h1200, 8'h12, 16'h01FF, "R6");
    chk(addr_out === 24'h130010, "R6", addr_out, 24'h130010, "(dd),Y carry");
    xact(3'd1, 8'h34, 16'h0, 16'h0020, 1'b1, 1'b1, 16'h1200, 8'h12, 16'h01FF, "R7");
    chk(addr_out === 24'h120010, "R7", addr_out, 24'h120010, "(dd),Y wrap");

    // stack-relative form, R6
    ovr[32'h01F5] = 8'h80; ovr[32'h01F6] = 8'hFF;
    xact(3'd5, 8'h05, 16'h0, 16'h0080, 1'b1, 1'b0, 16'h0000, 8'h7F, 16'h01F0, "R6");
    chk(addr_out === 24'h800000, "R6", addr_out, 24'h800000, "stack form carry");
    xact(3'd5, 8'h05, 16'h0, 16'h0080, 1'b1, 1'b1, 16'h0000, 8'h7F, 16'h01F0, "R7");
    chk(addr_out === 24'h7F0000, "R7", addr_out, 24'h7F0000, "stack form wrap");

    // R8 long indexed crosses a bank even in emulation; Y narrowed (R9)
    ovr[32'h0040] = 8'hF0; ovr[32'h0041] = 8'hFF; ovr[32'h0042] = 8'h03;
    xact(3'd4, 8'h40, 16'h0, 16'h1234, 1'b1, 1'b1, 16'h0000, 8'h00, 16'h01FF, "R8");
    chk(addr_out === 24'h040024, "R8", addr_out, 24'h040024, "[dd],Y cross");
    xact(3'd3, 8'h40, 16'h0, 16'h1234, 1'b1, 1'b0, 16'h0000, 8'h55, 16'h01FF, "R8");
    chk(addr_out === 24'h03FFF0, "R8", addr_out, 24'h03FFF0, "[dd]");

    // R4 pre-index, 8-bit cut in emulation, full width in native
    ovr[32'h2010] = 8'hCD; ovr[32'h2011] = 8'hAB;
    ovr[32'h2210] = 8'h11; ovr[32'h2211] = 8'h22;
    xact(3'd2, 8'hF0, 16'h0120, 16'hFFFF, 1'b1, 1'b1, 16'h2000, 8'h05, 16'h01FF, "R4");
    chk(addr_out === 24'h05ABCD, "R4", addr_out, 24'h05ABCD, "(dd,X) emulation");
    xact(3'd2, 8'hF0, 16'h0120, 16'hFFFF, 1'b1, 1'b0, 16'h2000, 8'h05, 16'h01FF, "R4");
    chk(addr_out === 24'h052211, "R4", addr_out, 24'h052211, "(dd,X) native");

    // R3 pointer location wraps from FFFF to 0000
    ovr[32'hFFFF] = 8'h56; ovr[32'h0000] = 8'h34; ovr[32'h0001] = 8'h12;
    stall_pct = 50;
    xact(3'd3, 8'h0F, 16'h0, 16'h0, 1'b1, 1'b0, 16'hFFF0, 8'h00, 16'h01FF, "R3");
    chk(addr_out === 24'h123456, "R3", addr_out, 24'h123456, "offset wrap");
    stall_pct = 0;

    // R9 narrow Y in native mode
    ovr[32'h0300] = 8'h00; ovr[32'h0301] = 8'h10;
    xact(3'd1, 8'h00, 16'h0, 16'hAB10, 1'b0, 1'b0, 16'h0300, 8'h00, 16'h01FF, "R9");
    chk(addr_out === 24'h001010, "R9", addr_out, 24'h001010, "narrow Y");

    // R5 plain pointer
    ovr[32'h0102] = 8'h78; ovr[32'h0103] = 8'h56;
    xact(3'd0, 8'h02, 16'h0, 16'h00FF, 1'b1, 1'b0, 16'h0100, 8'h9A, 16'h01FF, "R5");
    chk(addr_out === 24'h9A5678, "R5", addr_out, 24'h9A5678, "(dd)");

    // R11 second start during a stalled fetch, with changed inputs
    stall_pct = 60;
    @(negedge clk); #1;
    set_in(3'd0, 8'h02, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0100, 8'h9A, 16'h01FF);
    cur_tag = "R11";
    start = 1'b1;
    @(negedge clk); #1; start = 1'b0;
    @(negedge clk); #1;
    set_in(3'd4, 8'h40, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0000, 8'h00, 16'h01FF);
    start = 1'b1;
    @(negedge clk); #1; start = 1'b0;
    wait_idle();
    chk(addr_out === 24'h9A5678, "R11", addr_out, 24'h9A5678, "start while busy");
    stall_pct = 0;

    // R11 unknown mode codes start nothing
    xact(3'd6, 8'h02, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0100, 8'h11, 16'h01FF, "R11");
    xact(3'd7, 8'h02, 16'h0, 16'h0, 1'b1, 1'b0, 16'h0100, 8'h11, 16'h01FF, "R11");
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0 && addr_out === 24'h9A5678, "R11", addr_out, 24'h9A5678,
        "unknown mode");

    // random sweep with and without stalls
    for (int i = 0; i < 300; i++) begin
      stall_pct = (i % 3 == 0) ? 0 : 40;
      xact(3'($urandom % 8), 8'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), 16'($urandom),
           "R12");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule